// File: doc/BRIEF.md
# A/D converter control and status register

This block is an 8-bit control/status register for an analog-to-digital converter. It sits on a simple CPU register bus at one decoded address. The register holds six fields: a conversion-end flag, an interrupt enable, a start bit, a scan/single mode select, a clock select and a 3-bit channel number. The start, mode, clock and channel fields are driven out to the converter core.

The converter core reports each finished conversion with a one-cycle pulse and the number of the channel it finished. In single mode any completion sets the end flag. In scan mode the converter walks the channels from 0 up to the programmed channel number. The flag sets only when that highest channel reports done.

Software cannot set the flag. To clear it, software first reads the register while the flag is 1 and then writes 0 to bit 7. A service acknowledge from a data-transfer controller also clears the flag. An interrupt request is raised while both the flag and the enable are 1. A standby input returns the register to zero.

Top module: `adc_csr_unit`

## Requirements
- R1: After reset, and in the cycle after `standby` is high, the register reads 0x00. Standby takes priority over every other event.
- R2: The bit layout from bit 7 down to bit 0 is: end flag, interrupt enable, start, scan select, clock select, and channel bits 2..0. Bits 6..0 are plain read/write.
- R3: A bus write with bit 7 = 1 never sets the end flag.
- R4: A read that returns bit 7 = 1 arms a clear. The next write to the register with bit 7 = 0 then clears the flag. Any write to the register cancels the arming.
- R5: A write of 0 to bit 7 that is not preceded by an armed read leaves the flag unchanged.
- R6: A high `dtc_ack` clears the end flag.
- R7: In single mode (bit 4 = 0), any `conv_done` pulse sets the flag at the next clock edge.
- R8: In scan mode (bit 4 = 1), the flag sets only on a `conv_done` whose `conv_chan` equals the channel field. Completions on lower channels leave the flag clear.
- R9: `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R10: If a completion that sets the flag coincides with a software clear or with `dtc_ack`, the flag stays 1.
- R11: Accesses to any other address neither change the register nor return its data. `bus_rdata` is 0 unless the register is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby | input | 1 | Standby; clears the register |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (0 when not selected) |
| conv_done | input | 1 | Converter completion pulse |
| conv_chan | input | 3 | Channel just completed |
| dtc_ack | input | 1 | Transfer-controller service acknowledge |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | Start field |
| conv_scan | output | 1 | Scan mode field |
| conv_clksel | output | 1 | Clock select field |
| conv_ch | output | 3 | Channel field |

## Verification
The assertions check on every cycle that:
- standby empties the register;
- a software write never sets the flag;
- an unarmed write of 0 and a coincident completion leave the flag set;
- an acknowledge clears the flag;
- a rising flag with the enable set raises `irq`.

Other behaviours can only be shown by the bench's scenarios, which run whole sequences:
- the read-then-write clearing order and the cancelling of the arming by a write of 1;
- scan-mode completion on only the last channel;
- address decoding.

// File: rtl/adc_csr_unit.sv
module adc_csr_unit #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              conv_done,
  input  logic [2:0]        conv_chan,
  input  logic              dtc_ack,
  output logic              irq,
  output logic              conv_start,
  output logic              conv_scan,
  output logic              conv_clksel,
  output logic [2:0]        conv_ch
);
  logic       flag, armed;
  logic [6:0] ctl;

  wire hit    = (bus_addr == CSR_ADDR);
  wire wr_hit = bus_wr && hit;
  wire rd_hit = bus_rd && hit;
  wire set_ev = conv_done && (!ctl[4] || conv_chan == ctl[2:0]);
  wire clr_ev = dtc_ack || (wr_hit && armed && !bus_wdata[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      ctl   <= '0;
    end else if (standby) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      ctl   <= '0;
    end else begin
      if (set_ev)      flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
      if (wr_hit)      armed <= 1'b0;
      else if (rd_hit && flag) armed <= 1'b1;
      if (wr_hit)      ctl <= bus_wdata[6:0];
    end
  end

  assign bus_rdata   = rd_hit ? {flag, ctl} : 8'h00;
  assign irq         = flag && ctl[6];
  assign conv_start  = ctl[5];
  assign conv_scan   = ctl[4];
  assign conv_clksel = ctl[3];
  assign conv_ch     = ctl[2:0];

  AST_STANDBY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!flag && ctl == '0)); // R1
  AST_SW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !flag && !conv_done) |=> !flag); // R3
  AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !armed && flag && !dtc_ack && !standby) |=> flag); // R5
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_ack && !conv_done) |=> !flag); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_scan && !standby) |=> flag); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && ctl[6]) |-> irq); // R9
endmodule

// File: tb/adc_csr_unit_bench.sv
module adc_csr_unit_bench;
  localparam logic [3:0] A = 4'h8;
  logic clk = 0, rst_n = 0, standby = 0, bus_wr = 0, bus_rd = 0, conv_done = 0, dtc_ack = 0;
  logic [3:0] bus_addr = A;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [2:0] conv_chan = 0, conv_ch;
  logic irq, conv_start, conv_scan, conv_clksel;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  adc_csr_unit u_adc_csr_unit (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v, logic [3:0] a = A);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = A;
  endtask

  task automatic rd(output logic [7:0] v, input logic [3:0] a = A);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = A;
  endtask

  task automatic done(logic [2:0] ch);
    @(negedge clk); conv_chan = ch; conv_done = 1;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic t_reset();
    rd(d); chk("R1 reset", d, 8'h00); chk("R9 irq reset", {7'd0, irq}, 0);
  endtask

  task automatic t_rw();
    wr(8'h7F); rd(d); chk("R2 rw bits", d, 8'h7F);
    chk("R2 fields", {conv_start, conv_scan, conv_clksel, conv_ch}, 8'h3F);
    wr(8'h80); rd(d); chk("R3 sw no set", d, 8'h00);
  endtask

  task automatic t_single();
    wr(8'h42); done(3'd5); rd(d); chk("R7 single set", d, 8'hC2);
    chk("R9 irq on", {7'd0, irq}, 1);
    wr(8'hC2); wr(8'h42); rd(d); chk("R5 unarmed hold", d, 8'hC2);
    wr(8'h42); rd(d); chk("R4 armed clear", d, 8'h42);
    chk("R9 irq off", {7'd0, irq}, 0);
  endtask

  task automatic t_ack();
    wr(8'h02); done(3'd0);
    chk("R9 ie=0 no irq", {7'd0, irq}, 0);
    @(negedge clk); dtc_ack = 1; @(negedge clk); dtc_ack = 0;
    rd(d); chk("R6 ack clear", d, 8'h02);
  endtask

  task automatic t_scan();
    wr(8'h53);
    for (int c = 0; c < 3; c++) done(3'(c));
    rd(d); chk("R8 scan partial", d, 8'h53);
    done(3'd3); rd(d); chk("R8 scan last", d, 8'hD3);
    chk("R9 irq scan", {7'd0, irq}, 1);
  endtask

  task automatic t_collide();
    wr(8'h42); done(3'd1); rd(d);
    @(negedge clk); bus_wdata = 8'h42; bus_wr = 1; conv_done = 1;
    @(negedge clk); bus_wr = 0; conv_done = 0;
    rd(d); chk("R10 clear vs done", d, 8'hC2);
    @(negedge clk); dtc_ack = 1; conv_done = 1;
    @(negedge clk); dtc_ack = 0; conv_done = 0;
    rd(d); chk("R10 ack vs done", d, 8'hC2);
  endtask

  task automatic t_addr();
    wr(8'h15, 4'h3); rd(d); chk("R11 other addr no write", d, 8'hC2);
    rd(d, 4'h3); chk("R11 other addr rdata", d, 8'h00);
    @(negedge clk); #1 chk("R11 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_standby();
    wr(8'h7F); done(3'd7);
    @(negedge clk); standby = 1; conv_done = 1; conv_chan = 3'd7;
    @(negedge clk); standby = 0; conv_done = 0;
    rd(d); chk("R1 standby clear", d, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset(); t_rw(); t_single(); t_ack(); t_scan();
        t_collide(); t_addr(); t_standby();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++; $display("FAIL watchdog");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule